// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of a small pool of equal-sized packet buffer pages inside a network controller. An occupancy bitmap records which pages are in use. Three shift-style queues carry page numbers: the transmit queue holds frames waiting to go out, the completion queue holds frames already sent, and the receive queue holds frames that have arrived. Software drives the pool through a one-byte command written to `cmd_byte`. The receive and transmit engines claim pages through `rx_req` and move pages through `tx_take`.

Four interrupt causes live in a status byte: receive (bit 0), transmit done (bit 1), transmit queue empty (bit 2) and allocation done (bit 3). A mask byte gates the status byte onto one interrupt line. The read side shows the number of free pages, the latched allocation result and the head of each queue. When there is no valid page number, the code 0x80 is shown.

Top module: `pq_page_mmu`

## Requirements
- R1: An allocation always takes the lowest-numbered clear bit of the bitmap and sets it. If no bit is clear, `alloc_result` becomes 0x80.
- R2: The operation comes from `cmd_byte[7:5]`, and bits [4:0] are ignored. The codes are: 0 no-op, 1 allocate for transmit, 2 empty the pool (bitmap, all three queues and any pending allocation), 3 drop the receive head, 4 drop the receive head and free its page, 5 free page `page_sel`, 6 append `page_sel` to the transmit queue, 7 empty the transmit and completion queues.
- R3: Operation 1 clears status bit 3. On success it sets bit 3 again and latches the page number into `alloc_result`.
- R4: An allocation that fails stays pending and is retried on every page release. On the first success it latches the page, sets status bit 3 and stops being pending.
- R5: Status bit 2 reads 1 whenever the transmit queue is empty. Status bit 1 reads 1 whenever the completion queue holds an entry. Each bit stays set after its condition ends, until it is acknowledged.
- R6: `irq` is high exactly when `int_status & mask` is non-zero. The mask is loaded by `mask_we`.
- R7: An acknowledge write clears only the status bits in `ack_byte & 0xD6`. When `ack_byte` bit 1 is set, the write also removes the head of the completion queue.
- R8: After reset, the status reads 0x04, every page is free, every queue head reads 0x80 and `alloc_result` reads 0x80.
- R9: Operations 3 and 4 leave status bit 0 set if entries remain in the receive queue, and clear it if the queue becomes empty.
- R10: Appending to a full transmit queue is ignored. A `page_sel` value not below the page count is ignored by operations 5 and 6.
- R11: `free_pages` equals the number of clear bits in the bitmap.
- R12: Each queue is first-in first-out, and the head of an empty queue reads 0x80.
- R13: `rx_grant` is high when `rx_req` is high, no command is written in that cycle, a page is free and the receive queue has room. A grant claims page `rx_page`, which is the lowest free page, queues it for receive and sets status bit 0.
- R14: When no command is written, `tx_take` moves the head of a non-empty transmit queue onto the completion queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte, operation in bits [7:5] |
| page_sel | input | 8 | Page number used by release and append |
| ack_we | input | 1 | Interrupt acknowledge write strobe |
| ack_byte | input | 8 | Acknowledge value |
| mask_we | input | 1 | Mask write strobe |
| mask_byte | input | 8 | New interrupt mask |
| rx_req | input | 1 | Receive engine asks for a page |
| rx_grant | output | 1 | Page granted to the receive engine this cycle |
| rx_page | output | 8 | Page given with the grant |
| tx_take | input | 1 | Transmit engine finished the queue head |
| tx_head | output | 8 | Transmit queue head, 0x80 when empty |
| done_head | output | 8 | Completion queue head, 0x80 when empty |
| rx_head | output | 8 | Receive queue head, 0x80 when empty |
| alloc_result | output | 8 | Latched allocation result |
| free_pages | output | 8 | Count of free pages |
| int_status | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt line |

## Verification
The hardest state to reach is a transmit allocation left pending while the pool is full, which is then served by a later release. Random traffic alone rarely fills every page and then frees one page while a request is still waiting. The stimulus therefore includes a directed run: it claims every page, makes one more request that fails, and then frees a page in the middle of the pool. A random phase with weighted commands and out-of-range page numbers follows. Every output is compared each cycle with a bench-side model.

// File: rtl/pq_pkg.sv
package pq_pkg;
   localparam logic [7:0] NO_PAGE  = 8'h80;
   localparam logic [7:0] ACK_MASK = 8'hD6;
   localparam int ST_RCV   = 0;
   localparam int ST_TXD   = 1;
   localparam int ST_TXE   = 2;
   localparam int ST_ALLOC = 3;

   typedef enum logic [2:0] {
      OP_NOP        = 3'd0,
      OP_ALLOC_TX   = 3'd1,
      OP_RESET_POOL = 3'd2,
      OP_RX_DROP    = 3'd3,
      OP_RX_FREE    = 3'd4,
      OP_RELEASE    = 3'd5,
      OP_TX_ENQ     = 3'd6,
      OP_TX_FLUSH   = 3'd7
   } op_e;
endpackage

// File: rtl/pq_shift_fifo.sv
module pq_shift_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);
   logic [W-1:0]  slot_q [DEPTH];
   logic [CW-1:0] cnt_q;
   logic          do_pop, do_push;
   logic [CW-1:0] wr_idx;

   assign do_pop  = pop && (cnt_q != '0);
   assign do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
   assign wr_idx  = cnt_q - CW'(do_pop);
   assign head    = slot_q[0];
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else                 cnt_q <= cnt_q - CW'(do_pop) + CW'(do_push);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i < DEPTH - 1) begin : g_mid
         always_ff @(posedge clk) begin
            if (!rst_n)                             slot_q[i] <= '0;
            else if (do_push && wr_idx == CW'(i))   slot_q[i] <= din;
            else if (do_pop)                        slot_q[i] <= slot_q[i+1];
         end
      end else begin : g_last
         always_ff @(posedge clk) begin
            if (!rst_n)                             slot_q[i] <= '0;
            else if (do_push && wr_idx == CW'(i))   slot_q[i] <= din;
         end
      end
   end

   // R10: a push into a full queue without a pop leaves it full
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CW'(DEPTH) && push && !pop && !clear) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/pq_page_map.sv
module pq_page_map #(
   parameter int PAGES = 4,
   localparam int IW   = $clog2(PAGES),
   localparam int FCW  = $clog2(PAGES + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           rel_en,
   input  logic [IW-1:0]  rel_idx,
   input  logic           take_en,
   output logic [IW-1:0]  pick_idx,
   output logic           pick_ok,
   output logic [FCW-1:0] free_cnt
);
   logic [PAGES-1:0] map_q, rel_mask, avail;

   assign rel_mask = rel_en ? (PAGES'(1) << rel_idx) : '0;
   assign avail    = map_q & ~rel_mask;
   assign pick_ok  = ~&avail;

   always_comb begin
      pick_idx = '0;
      for (int i = PAGES - 1; i >= 0; i--)
         if (!avail[i]) pick_idx = IW'(i);
   end

   always_comb begin
      free_cnt = '0;
      for (int i = 0; i < PAGES; i++)
         free_cnt = free_cnt + FCW'(!map_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) map_q <= '0;
      else                 map_q <= avail | (take_en ? (PAGES'(1) << pick_idx) : '0);
   end

   // R1: a page is only taken when one is free
   p_take_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |-> pick_ok);
   // R1: the taken page is in use on the next cycle
   p_take_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (take_en && !clear) |=> map_q[$past(pick_idx)]);
endmodule

// File: rtl/pq_page_mmu.sv
module pq_page_mmu
   import pq_pkg::*;
#(
   parameter int PAGES = 4,
   localparam int IW   = $clog2(PAGES),
   localparam int CW   = $clog2(PAGES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic [7:0] cmd_byte,
   input  logic [7:0] page_sel,
   input  logic       ack_we,
   input  logic [7:0] ack_byte,
   input  logic       mask_we,
   input  logic [7:0] mask_byte,
   input  logic       rx_req,
   output logic       rx_grant,
   output logic [7:0] rx_page,
   input  logic       tx_take,
   output logic [7:0] tx_head,
   output logic [7:0] done_head,
   output logic [7:0] rx_head,
   output logic [7:0] alloc_result,
   output logic [7:0] free_pages,
   output logic [7:0] int_status,
   output logic       irq
);
   if (PAGES < 2 || PAGES > 64) begin : g_bad_pages
      $error("pq_page_mmu: PAGES must lie in 2..64");
   end

   op_e           op;
   logic          is_alloc, is_rstpool, is_rxdrop, is_rxfree, is_rel, is_enq, is_flush;
   logic          sel_ok, rel_en, take_alloc, take_en, tx_take_ok, rx_pop, q_clear;
   logic [IW-1:0] rel_idx, pick_idx, txq_hd, dq_hd, rxq_hd;
   logic          pick_ok;
   logic [CW-1:0] txq_cnt, dq_cnt, rxq_cnt, free_cnt;
   logic          pend_q;
   logic [7:0]    res_q, st_q, mask_q, st_set, st_clr, st_cond;
   logic          unused_cmd_low;

   assign unused_cmd_low = ^cmd_byte[4:0];
   assign op         = op_e'(cmd_byte[7:5]);
   assign is_alloc   = cmd_we && op == OP_ALLOC_TX;
   assign is_rstpool = cmd_we && op == OP_RESET_POOL;
   assign is_rxdrop  = cmd_we && op == OP_RX_DROP;
   assign is_rxfree  = cmd_we && op == OP_RX_FREE;
   assign is_rel     = cmd_we && op == OP_RELEASE;
   assign is_enq     = cmd_we && op == OP_TX_ENQ;
   assign is_flush   = cmd_we && op == OP_TX_FLUSH;

   assign sel_ok     = page_sel < 8'(PAGES);
   assign rel_en     = (is_rxfree && rxq_cnt != '0) || (is_rel && sel_ok);
   assign rel_idx    = is_rxfree ? rxq_hd : page_sel[IW-1:0];
   assign take_alloc = (is_alloc || (pend_q && rel_en)) && pick_ok;
   assign rx_grant   = rx_req && !cmd_we && pick_ok && (rxq_cnt != CW'(PAGES));
   assign take_en    = take_alloc || rx_grant;
   assign tx_take_ok = tx_take && !cmd_we && (txq_cnt != '0);
   assign rx_pop     = is_rxdrop || is_rxfree;
   assign q_clear    = is_rstpool || is_flush;
   assign rx_page    = 8'(pick_idx);

   pq_page_map #(.PAGES(PAGES)) i_map (
      .clk, .rst_n, .clear(is_rstpool), .rel_en, .rel_idx, .take_en,
      .pick_idx, .pick_ok, .free_cnt);

   pq_shift_fifo #(.DEPTH(PAGES), .W(IW)) i_txq (
      .clk, .rst_n, .clear(q_clear), .push(is_enq && sel_ok), .pop(tx_take_ok),
      .din(page_sel[IW-1:0]), .head(txq_hd), .count(txq_cnt));

   pq_shift_fifo #(.DEPTH(PAGES), .W(IW)) i_doneq (
      .clk, .rst_n, .clear(q_clear), .push(tx_take_ok), .pop(ack_we && ack_byte[ST_TXD]),
      .din(txq_hd), .head(dq_hd), .count(dq_cnt));

   pq_shift_fifo #(.DEPTH(PAGES), .W(IW)) i_rxq (
      .clk, .rst_n, .clear(is_rstpool), .push(rx_grant), .pop(rx_pop),
      .din(pick_idx), .head(rxq_hd), .count(rxq_cnt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         res_q  <= NO_PAGE;
      end else if (is_rstpool) begin
         pend_q <= 1'b0;
      end else if (is_alloc && !pick_ok) begin
         pend_q <= 1'b1;
         res_q  <= NO_PAGE;
      end else if (take_alloc) begin
         pend_q <= 1'b0;
         res_q  <= 8'(pick_idx);
      end
   end

   always_comb begin
      st_cond = '0;
      st_cond[ST_TXE] = (txq_cnt == '0);
      st_cond[ST_TXD] = (dq_cnt != '0);
      st_set = '0;
      st_clr = ack_we ? (ack_byte & ACK_MASK) : '0;
      if (is_alloc)   st_clr[ST_ALLOC] = 1'b1;
      if (take_alloc) st_set[ST_ALLOC] = 1'b1;
      if (rx_grant)   st_set[ST_RCV]   = 1'b1;
      if (rx_pop) begin
         if (rxq_cnt >= CW'(2)) st_set[ST_RCV] = 1'b1;
         else                   st_clr[ST_RCV] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= 8'h04;
         mask_q <= '0;
      end else begin
         st_q <= (st_q & ~st_clr) | st_set | st_cond;
         if (mask_we) mask_q <= mask_byte;
      end
   end

   assign int_status   = st_q | st_cond;
   assign irq          = |(int_status & mask_q);
   assign alloc_result = res_q;
   assign free_pages   = 8'(free_cnt);
   assign tx_head      = (txq_cnt == '0) ? NO_PAGE : 8'(txq_hd);
   assign done_head    = (dq_cnt == '0)  ? NO_PAGE : 8'(dq_hd);
   assign rx_head      = (rxq_cnt == '0) ? NO_PAGE : 8'(rxq_hd);

   // R2: emptying the pool frees every page
   p_pool_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_rstpool |=> (free_pages == 8'(PAGES)));
   // R3: a successful transmit allocation raises the allocation flag
   p_alloc_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_alloc && pick_ok) |=> int_status[ST_ALLOC]);
   // R4: a failed allocation reports the failure code
   p_alloc_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_alloc && !pick_ok) |=> (alloc_result == NO_PAGE));
   // R5: queue-empty flag holds until acknowledged
   p_txe_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_status[ST_TXE] && !(ack_we && ack_byte[ST_TXE])) |=> int_status[ST_TXE]);
   // R6: a zero mask silences the line
   p_mask_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && mask_byte == 8'h00) |=> !irq);
   // R7: acknowledge never clears the receive flag
   p_ack_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int_status[ST_RCV] && !cmd_we) |=> int_status[ST_RCV]);
endmodule

// File: tb/test_pq_page_mmu.sv
`timescale 1ns/1ps
module test_pq_page_mmu;
   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cmd_we, ack_we, mask_we, rx_req, tx_take;
   logic [7:0] cmd_byte, page_sel, ack_byte, mask_byte;
   logic       rx_grant, irq;
   logic [7:0] rx_page, tx_head, done_head, rx_head, alloc_result, free_pages, int_status;

   always #2.5 clk = ~clk;

   pq_page_mmu #(.PAGES(N)) i_pq_page_mmu (
      .clk, .rst_n, .cmd_we, .cmd_byte, .page_sel, .ack_we, .ack_byte,
      .mask_we, .mask_byte, .rx_req, .rx_grant, .rx_page, .tx_take,
      .tx_head, .done_head, .rx_head, .alloc_result, .free_pages,
      .int_status, .irq);

   int    n_chk = 0, n_fail = 0;
   string phase = "R8";

   bit [N-1:0] m_map;
   int   m_txq[N], m_dq[N], m_rxq[N];
   int   m_txn, m_dn, m_rxn;
   bit [7:0] m_st, m_mk, m_res;
   bit   m_pend;

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s/%s: actual %02h expected %02h", phase, tag, act, exp);
      end
   endtask

   function automatic int lowest_free(bit [N-1:0] m);
      for (int i = 0; i < N; i++) if (!m[i]) return i;
      return -1;
   endfunction

   function automatic bit [7:0] head8(int n, int v);
      return (n == 0) ? 8'h80 : 8'(v);
   endfunction

   function automatic bit [7:0] cond_now();
      return ((m_txn == 0) ? 8'h04 : 8'h00) | ((m_dn != 0) ? 8'h02 : 8'h00);
   endfunction

   task automatic check_state();
      bit [7:0] vis;
      vis = m_st | cond_now();
      chk("R11 free", free_pages, 8'(N - $countones(m_map)));
      chk("R1 result", alloc_result, m_res);
      chk("R5 status", int_status, vis);
      chk("R6 irq", {7'd0, irq}, {7'd0, (vis & m_mk) != 0});
      chk("R12 txhead", tx_head, head8(m_txn, m_txq[0]));
      chk("R14 donehead", done_head, head8(m_dn, m_dq[0]));
      chk("R9 rxhead", rx_head, head8(m_rxn, m_rxq[0]));
   endtask

   task automatic m_alloc_tx(ref bit [7:0] set);
      int p;
      p = lowest_free(m_map);
      m_map[p] = 1'b1; m_res = 8'(p); m_pend = 1'b0; set[3] = 1'b1;
   endtask

   task automatic step(bit cw, bit [7:0] cb, bit [7:0] sp, bit aw, bit [7:0] ab,
                       bit mw, bit [7:0] mb, bit rq, bit tk);
      bit [7:0] set, clr, cnd;
      bit rx_g, tk_g;
      int rel, op, p;
      cmd_we = cw; cmd_byte = cb; page_sel = sp; ack_we = aw; ack_byte = ab;
      mask_we = mw; mask_byte = mb; rx_req = rq; tx_take = tk;
      #1;
      cnd  = cond_now();
      rx_g = rq && !cw && (lowest_free(m_map) >= 0) && (m_rxn < N);
      tk_g = tk && !cw && (m_txn > 0);
      chk("R13 grant", {7'd0, rx_grant}, {7'd0, rx_g});
      if (rx_g) chk("R13 page", rx_page, 8'(lowest_free(m_map)));
      set = 0; clr = aw ? (ab & 8'hD6) : 8'h00; rel = -1;
      if (aw && ab[1] && m_dn > 0) begin
         for (int i = 0; i < N - 1; i++) m_dq[i] = m_dq[i+1];
         m_dn--;
      end
      op = cw ? int'(cb[7:5]) : 0;
      case (op)
         1: begin
            clr[3] = 1'b1;
            if (lowest_free(m_map) >= 0) m_alloc_tx(set);
            else begin m_res = 8'h80; m_pend = 1'b1; end
         end
         2: begin m_map = '0; m_txn = 0; m_dn = 0; m_rxn = 0; m_pend = 1'b0; end
         3, 4: begin
            if (m_rxn > 0) begin
               if (op == 4) rel = m_rxq[0];
               for (int i = 0; i < N - 1; i++) m_rxq[i] = m_rxq[i+1];
               m_rxn--;
            end
            if (m_rxn > 0) set[0] = 1'b1; else clr[0] = 1'b1;
         end
         5: if (sp < N) rel = int'(sp);
         6: if (sp < N && m_txn < N) begin m_txq[m_txn] = int'(sp); m_txn++; end
         7: begin m_txn = 0; m_dn = 0; end
         default: ;
      endcase
      if (rel >= 0) begin
         m_map[rel] = 1'b0;
         if (m_pend && lowest_free(m_map) >= 0) m_alloc_tx(set);
      end
      if (rx_g) begin
         p = lowest_free(m_map);
         m_map[p] = 1'b1; m_rxq[m_rxn] = p; m_rxn++; set[0] = 1'b1;
      end
      if (tk_g) begin
         p = m_txq[0];
         for (int i = 0; i < N - 1; i++) m_txq[i] = m_txq[i+1];
         m_txn--;
         if (m_dn < N) begin m_dq[m_dn] = p; m_dn++; end
      end
      m_st = (m_st & ~clr) | set | cnd;
      if (mw) m_mk = mb;
      @(negedge clk);
      check_state();
   endtask

   task automatic cmd(bit [2:0] op, bit [7:0] sp);
      step(1'b1, {op, 5'd0}, sp, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; cmd_we = 0; cmd_byte = 0; page_sel = 0; ack_we = 0; ack_byte = 0;
      mask_we = 0; mask_byte = 0; rx_req = 0; tx_take = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_map = '0; m_txn = 0; m_dn = 0; m_rxn = 0; m_st = 8'h04; m_mk = 0; m_res = 8'h80; m_pend = 0;
      for (int i = 0; i < N; i++) begin m_txq[i] = 0; m_dq[i] = 0; m_rxq[i] = 0; end
      phase = "R8";
      check_state();
      phase = "R2";
      step(1'b1, 8'h1F, 8'h00, 1'b0, 0, 1'b1, 8'hFF, 1'b0, 1'b0);
      phase = "R3";
      for (int i = 0; i < N; i++) cmd(3'd1, 8'h00);
      phase = "R4";
      cmd(3'd1, 8'h00);
      cmd(3'd5, 8'(N));
      cmd(3'd5, 8'd2);
      cmd(3'd5, 8'd1);
      phase = "R10";
      for (int i = 0; i < N + 1; i++) cmd(3'd6, 8'(i % N));
      for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
      phase = "R7";
      step(0, 0, 0, 1'b1, 8'hFF, 0, 0, 1'b0, 1'b0);
      step(0, 0, 0, 1'b1, 8'h02, 0, 0, 1'b0, 1'b0);
      phase = "R9";
      cmd(3'd2, 8'h00);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0);
      cmd(3'd4, 8'h00);
      cmd(3'd3, 8'h00);
      cmd(3'd4, 8'h00);
      cmd(3'd3, 8'h00);
      phase = "RAND";
      for (int n = 0; n < 4000; n++) begin
         bit [2:0] op;
         op = 3'($urandom_range(0, 7));
         if (op == 3'd2 && $urandom_range(0, 3) != 0) op = 3'd1;
         step($urandom_range(0, 1) == 1, {op, 5'($urandom)}, 8'($urandom_range(0, N)),
              $urandom_range(0, 6) == 0, 8'($urandom),
              $urandom_range(0, 9) == 0, 8'($urandom),
              $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule